// File: doc/BRIEF.md
# Offset-Adjusted Programmable Feedback Divider

This block divides a VCO-derived clock by a programmable ratio to produce the feedback strobe of a frequency synthesizer loop. It has a 14-bit parallel divide word and a single select line. When the select is low, the block adds a fixed constant of 856 to the divide word. This moves the synthesized frequency by one intermediate-frequency step for transceiver use. When the select is high, the divide word is used unchanged.

A down-counter is loaded with the resulting ratio. It counts one step per input clock. In the clock cycle where it stands at zero, it raises a strobe for one cycle and then reloads. The divide word and the select are sampled only at a reload. A new word can therefore be written at any time without disturbing the count in progress. Ratios below two are raised to two, so the output never sticks high or stops.

Top module: `fbdiv_offset`

## Requirements
- R1: With `bypass_ofs` high, the strobe period in input clock cycles equals the 14-bit `div_val`, for values from 2 to 16383. Bit 0 is the least significant bit.
- R2: With `bypass_ofs` low, the strobe period equals `div_val` plus 856.
- R3: The sum of the divide word and the offset is formed at 15 bits. `div_val` = 16383 with the offset applied gives a period of 17239 cycles, with no wrap-around.
- R4: A ratio (after the offset) of 0 or 1 gives a period of 2 cycles. A ratio of 2 also gives a period of 2.
- R5: `div_pulse` is high for exactly one input clock cycle per period, in the cycle where the counter is at zero.
- R6: `div_val` and `bypass_ofs` are sampled only at a reload edge. A reload edge is the rising edge that ends a strobe cycle, or the first rising edge after reset. A change at any other time does not alter the period in progress. It takes effect for the period that follows the next reload.
- R7: While `rst_n` is low, `div_pulse` is low. After release, the first rising edge loads the ratio, and the first strobe appears after the ratio-th rising edge counted from release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO-derived input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 14 | Parallel divide word, bit 0 least significant |
| bypass_ofs | input | 1 | High: no offset; low: add 856 to the divide word |
| div_pulse | output | 1 | One-cycle divided output strobe |

## Verification
Two events can land on the same clock edge: the reload of the counter and a rewrite of the divide word or select. The bench provokes this by changing the inputs in the very cycle the strobe is high. The interval that follows must then follow the new ratio. The bench also rewrites the inputs a few cycles into a count. There, the current interval must keep the old ratio and only the next one may change. A queue of expected intervals is filled when the inputs change and is drained as strobes arrive, so any reload in the wrong cycle shows up as an interval mismatch.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

   // Bits needed to hold the largest word plus the fixed offset
   function automatic int sum_width(input int nw, input int ofs);
      longint top_val;
      top_val = (longint'(1) << nw) - 1 + longint'(ofs);
      return $clog2(top_val + 1);
   endfunction

endpackage

// File: rtl/fbdiv_reload_calc.sv
module fbdiv_reload_calc #(
   parameter int N_W     = 14,
   parameter int OFS_VAL = 856,
   parameter int MIN_DIV = 2,
   parameter int SUM_W   = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_W-1:0]   div_val,
   input  logic             bypass_ofs,
   output logic [SUM_W-1:0] load_val
);

   localparam logic [SUM_W-1:0] OFS_W = SUM_W'(OFS_VAL);
   localparam logic [SUM_W-1:0] MIN_W = SUM_W'(MIN_DIV);

   logic [SUM_W-1:0] raw_sum;

   generate
      if (OFS_VAL == 0) begin : g_no_adder
         logic unused_bypass;
         assign unused_bypass = bypass_ofs;
         assign raw_sum = SUM_W'(div_val);
      end else begin : g_adder
         always_comb begin
            raw_sum = SUM_W'(div_val);
            if (!bypass_ofs) begin
               raw_sum = raw_sum + OFS_W;
            end
         end
      end
   endgenerate

   // Raise tiny ratios to the floor
   always_comb begin
      if (raw_sum < MIN_W) begin
         load_val = MIN_W;
      end else begin
         load_val = raw_sum;
      end
   end

   // R3: ratio never falls below the raw word (a wrapped sum would)
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_val >= SUM_W'(div_val));

endmodule

// File: rtl/fbdiv_count.sv
module fbdiv_count #(
   parameter int SUM_W   = 15,
   parameter int MIN_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUM_W-1:0] load_val,
   output logic             pulse
);

   logic [SUM_W-1:0] cnt;
   logic             armed;
   logic             reload;

   assign reload = !armed || (cnt == '0);
   assign pulse  = armed && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (reload) begin
            cnt <= load_val - SUM_W'(1);
         end else begin
            cnt <= cnt - SUM_W'(1);
         end
      end
   end

   // R5: strobe lasts a single cycle
   p_one_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   // R6: mid-count the counter only steps down, inputs ignored
   p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cnt != '0) |=> (cnt == $past(cnt) - SUM_W'(1)));

   // R4: any ratio taken at a reload respects the floor
   p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload |-> (load_val >= SUM_W'(MIN_DIV)));

   // R7: first edge after reset loads the ratio
   p_first_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> (cnt == $past(load_val) - SUM_W'(1)));

endmodule

// File: rtl/fbdiv_offset.sv
module fbdiv_offset #(
   parameter int N_W     = 14,
   parameter int OFS_VAL = 856,
   parameter int MIN_DIV = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N_W-1:0] div_val,
   input  logic           bypass_ofs,
   output logic           div_pulse
);

   localparam int SUM_W = fbdiv_pkg::sum_width(N_W, OFS_VAL);

   generate
      if (N_W < 2) begin : g_bad_width
         $error("fbdiv_offset: N_W must be at least 2");
      end
      if (OFS_VAL < 0) begin : g_bad_offset
         $error("fbdiv_offset: OFS_VAL must not be negative");
      end
      if (MIN_DIV < 2) begin : g_bad_floor
         $error("fbdiv_offset: MIN_DIV must be at least 2");
      end
      if (longint'(MIN_DIV) >= (longint'(1) << SUM_W)) begin : g_floor_wide
         $error("fbdiv_offset: MIN_DIV does not fit the counter");
      end
   endgenerate

   logic [SUM_W-1:0] load_val;

   fbdiv_reload_calc #(
      .N_W     (N_W),
      .OFS_VAL (OFS_VAL),
      .MIN_DIV (MIN_DIV),
      .SUM_W   (SUM_W)
   ) i_calc (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_val    (div_val),
      .bypass_ofs (bypass_ofs),
      .load_val   (load_val)
   );

   fbdiv_count #(
      .SUM_W   (SUM_W),
      .MIN_DIV (MIN_DIV)
   ) i_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_val (load_val),
      .pulse    (div_pulse)
   );

endmodule

// File: tb/test_fbdiv_offset.sv
module test_fbdiv_offset;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] div_val = 14'd5;
   logic        bypass_ofs = 1'b1;
   logic        div_pulse;

   int    checks = 0;
   int    errors = 0;
   int    exp_q[$];
   string tag_q[$];
   int    since = 0;
   bit    monitor_on = 1'b0;
   bit    prev_pulse = 1'b0;
   bit    finished = 1'b0;

   always #10 clk = ~clk;

   fbdiv_offset i_fbdiv_offset (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_val    (div_val),
      .bypass_ofs (bypass_ofs),
      .div_pulse  (div_pulse)
   );

   function automatic int ref_ratio(input int n, input bit byp);
      int s;
      s = n + (byp ? 0 : 856);
      return (s < 2) ? 2 : s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: measure interval between strobes and pop expectations
   always @(negedge clk) begin
      if (monitor_on) begin
         since++;
         if (div_pulse) begin
            check(!prev_pulse, "R5 strobe one cycle wide", 2, 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 strobe with no expected interval", since, 0);
            end else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(since == e, t, since, e);
            end
            since = 0;
         end
         prev_pulse = div_pulse;
      end
   end

   // Driver: at a strobe cycle (reload edge follows), set inputs, push ratio
   task automatic next_period(input int n, input bit byp, input string tag);
      do @(negedge clk); while (!div_pulse);
      div_val    = 14'(n);
      bypass_ofs = byp;
      exp_q.push_back(ref_ratio(n, byp));
      tag_q.push_back(tag);
   endtask

   // Same, then rewrite inputs some cycles into the count
   task automatic next_period_mid(input int n, input bit byp, input string tag,
                                  input int late_n, input bit late_byp, input int gap);
      next_period(n, byp, tag);
      repeat (gap) @(negedge clk);
      div_val    = 14'(late_n);
      bypass_ofs = late_byp;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      exp_q.push_back(5);
      tag_q.push_back("R7 first period after reset");
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(div_pulse == 1'b0, "R7 strobe low in reset", int'(div_pulse), 0);
      end
      rst_n = 1'b1;
      #1 monitor_on = 1'b1;

      next_period(5, 1'b1, "R1 N=5 no offset");
      next_period(37, 1'b1, "R1 N=37 no offset");
      next_period(3, 1'b1, "R1 N=3 no offset");
      next_period(2, 1'b1, "R4 N=2 boundary");
      next_period(1, 1'b1, "R4 N=1 floor");
      next_period(0, 1'b1, "R4 N=0 floor");
      next_period(0, 1'b0, "R2 N=0 with offset");
      next_period(100, 1'b0, "R2 N=100 with offset");
      next_period(16'h2000, 1'b1, "R1 bit 13 weight");
      next_period(16383, 1'b1, "R1 N=16383 no offset");
      next_period(16383, 1'b0, "R3 sum beyond 14 bits");
      next_period_mid(20, 1'b1, "R6 mid-count change ignored", 9, 1'b0, 4);
      next_period(9, 1'b0, "R6 late change used at reload");
      next_period_mid(6, 1'b1, "R6 change one cycle after reload ignored", 40, 1'b1, 1);
      next_period(4, 1'b1, "R6 reload-cycle write taken");
      next_period(4, 1'b1, "R1 tail N=4");

      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule